// File: doc/BRIEF.md
# I2C SCL Clock Divider with Standard and Fast Modes

This block derives the serial clock timing for an I2C bus master from the system clock. A 12-bit divider value N is built from two register fields. The low seven bits come from a clock-control byte, whose top bit also selects fast mode. The high five bits come from an extended clock-control field. Each SCL period is one low phase followed by one high phase. The length of the period is an affine function of N, and the function differs between the two modes.

The bus engine uses three outputs. A low-phase enable tells it to pull SCL down. A high-phase enable tells it to release SCL. A one-cycle toggle strobe marks the first cycle of every phase. In standard mode the two phases are nearly equal. In fast mode the low phase is about twice as long as the high phase.

The divider and the mode can be reprogrammed at any time, but a new setting is only taken when a period ends. If the divider is below 2, the block parks with SCL released and sends no strobes. It starts again one clock after a legal value appears.

Top module: `i2c_scl_divgen`

## Requirements
- R1: While reset is high and in the first cycle after it, scl_hi_en is 1, scl_lo_en is 0 and scl_tgl is 0; reset is synchronous and active high.
- R2: The divider is N = {ext_div_hi[4:0], clk_ctrl[6:0]}, so ext_div_hi[0] is divider bit 7. clk_ctrl[7] = 1 selects fast mode and 0 selects standard mode.
- R3: In standard mode the low phase lasts N+3 clocks and the high phase N+2 clocks, a period of 2N+5.
- R4: In fast mode the low phase lasts 2N+4 clocks and the high phase N+2 clocks, a period of 3N+6.
- R5: Exactly one of scl_lo_en and scl_hi_en is 1 in every cycle, and every period begins with its low phase.
- R6: scl_tgl is 1 for exactly the first cycle of each low phase and each high phase, and 0 in every other cycle.
- R7: A divider below 2 (N = 0 or 1) seen at a period boundary parks the block: scl_hi_en stays 1, scl_lo_en stays 0 and scl_tgl stays 0.
- R8: A change of divider or mode during a period does not alter that period; it applies from the next low phase on.
- R9: While parked, a legal divider starts a low phase, with scl_tgl, in the cycle after the clock edge that first sees it.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous reset, active high |
| clk_ctrl | input | 8 | Bit 7 fast-mode select, bits 6:0 low divider bits |
| ext_div_hi | input | 5 | Divider bits 11:7 |
| scl_lo_en | output | 1 | SCL low phase active (drive SCL low) |
| scl_hi_en | output | 1 | SCL high phase or parked (release SCL) |
| scl_tgl | output | 1 | One-cycle strobe on the first cycle of each phase |

## Verification
The main timing is measured phase by phase at several settings:
- Small and medium dividers in both modes. These separate the N+3 / N+2 standard split from the 2N+4 / N+2 fast split.
- A divider of 300. Its value only comes out right if the two register fields join at the correct bit.
- The all-ones divider in fast mode. This exercises the full counter width.
Reprogramming is tested by changing the mode and the divider in the first cycle of a low phase; the running period must keep the old timing and the next one must use the new timing. Both illegal values are applied: N = 1 while running, which must finish the period and then park, and N = 0 while parked. A return to a legal value then checks the one-cycle restart.

// File: rtl/i2c_scl_pkg.sv
package i2c_scl_pkg;

    // Register and divider geometry
    localparam int REG_W   = 8;
    localparam int LO_W    = 7;
    localparam int HI_W    = 5;
    localparam int DIV_W   = LO_W + HI_W;
    localparam int CNT_W   = DIV_W + 2;
    localparam int MIN_DIV = 2;

    // Phase-length offsets (clocks added to N or 2N)
    localparam int STD_LO_ADD  = 3;
    localparam int FAST_LO_ADD = 4;
    localparam int HI_ADD      = 2;

    typedef enum logic [1:0] {
        PH_IDLE = 2'd0,
        PH_LOW  = 2'd1,
        PH_HIGH = 2'd2
    } scl_phase_e;

    typedef struct packed {
        logic             fast;
        logic [DIV_W-1:0] div;
    } scl_cfg_t;

    function automatic logic [CNT_W-1:0] high_len(scl_cfg_t c);
        return CNT_W'(c.div) + CNT_W'(HI_ADD);
    endfunction

    function automatic logic [CNT_W-1:0] low_len(scl_cfg_t c);
        if (c.fast)
            return (CNT_W'(c.div) << 1) + CNT_W'(FAST_LO_ADD);
        else
            return CNT_W'(c.div) + CNT_W'(STD_LO_ADD);
    endfunction

    function automatic logic cfg_legal(scl_cfg_t c);
        return c.div >= DIV_W'(MIN_DIV);
    endfunction

endpackage

// File: rtl/scl_cfg_decode.sv
module scl_cfg_decode
    import i2c_scl_pkg::*;
(
    input  logic [REG_W-1:0] ctrl_reg,
    input  logic [HI_W-1:0]  ext_bits,
    output scl_cfg_t         cfg,
    output logic             legal
);
    // Low divider bits share the control byte with the mode select in its MSB
    always_comb begin
        cfg.fast = ctrl_reg[REG_W-1];
        cfg.div  = {ext_bits, ctrl_reg[LO_W-1:0]};
        legal    = cfg_legal(cfg);
    end
endmodule

// File: rtl/scl_phase_timer.sv
module scl_phase_timer
    import i2c_scl_pkg::*;
(
    input  logic             clk,
    input  logic             rst,
    input  scl_cfg_t         cfg_in,
    input  logic             legal_in,
    output scl_phase_e       phase,
    output logic [CNT_W-1:0] cnt,
    output scl_cfg_t         cfg_act,
    output logic             tgl
);
    scl_phase_e       phase_q;
    logic [CNT_W-1:0] cnt_q;
    scl_cfg_t         cfg_q;
    logic             tgl_q;
    logic             last_cyc;
    logic             may_start;

    // A new period may start from park, or when a high phase is ending
    always_comb begin
        last_cyc  = (cnt_q == '0);
        may_start = (phase_q == PH_IDLE) || (phase_q == PH_HIGH && last_cyc);
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            phase_q <= PH_IDLE;
            cnt_q   <= '0;
            cfg_q   <= '0;
            tgl_q   <= 1'b0;
        end else begin
            tgl_q <= 1'b0;
            if (may_start) begin
                if (legal_in) begin
                    phase_q <= PH_LOW;
                    cfg_q   <= cfg_in;
                    cnt_q   <= low_len(cfg_in) - CNT_W'(1);
                    tgl_q   <= 1'b1;
                end else begin
                    phase_q <= PH_IDLE;
                    cnt_q   <= '0;
                end
            end else if (phase_q == PH_LOW && last_cyc) begin
                phase_q <= PH_HIGH;
                cnt_q   <= high_len(cfg_q) - CNT_W'(1);
                tgl_q   <= 1'b1;
            end else begin
                cnt_q <= cnt_q - CNT_W'(1);
            end
        end
    end

    assign phase   = phase_q;
    assign cnt     = cnt_q;
    assign cfg_act = cfg_q;
    assign tgl     = tgl_q;
endmodule

// File: rtl/scl_out_map.sv
module scl_out_map
    import i2c_scl_pkg::*;
(
    input  scl_phase_e phase,
    input  logic       tgl_in,
    output logic       lo_en,
    output logic       hi_en,
    output logic       tgl_out
);
    // Parked counts as released: SCL is high whenever it is not driven low
    always_comb begin
        lo_en   = (phase == PH_LOW);
        hi_en   = (phase != PH_LOW);
        tgl_out = tgl_in;
    end
endmodule

// File: rtl/i2c_scl_divgen.sv
module i2c_scl_divgen
    import i2c_scl_pkg::*;
(
    input  logic             clk,
    input  logic             rst,
    input  logic [REG_W-1:0] clk_ctrl,
    input  logic [HI_W-1:0]  ext_div_hi,
    output logic             scl_lo_en,
    output logic             scl_hi_en,
    output logic             scl_tgl
);
    scl_cfg_t         cfg_w;
    scl_cfg_t         cfg_q_w;
    logic             legal_w;
    scl_phase_e       phase_w;
    logic [CNT_W-1:0] cnt_w;
    logic             tgl_w;

    scl_cfg_decode u_dec (
        .ctrl_reg (clk_ctrl),
        .ext_bits (ext_div_hi),
        .cfg      (cfg_w),
        .legal    (legal_w)
    );

    scl_phase_timer u_tmr (
        .clk      (clk),
        .rst      (rst),
        .cfg_in   (cfg_w),
        .legal_in (legal_w),
        .phase    (phase_w),
        .cnt      (cnt_w),
        .cfg_act  (cfg_q_w),
        .tgl      (tgl_w)
    );

    scl_out_map u_out (
        .phase   (phase_w),
        .tgl_in  (tgl_w),
        .lo_en   (scl_lo_en),
        .hi_en   (scl_hi_en),
        .tgl_out (scl_tgl)
    );
endmodule

// File: rtl/scl_divgen_chk.sv
module scl_divgen_chk
    import i2c_scl_pkg::*;
(
    input logic             clk,
    input logic             rst,
    input logic             lo,
    input logic             hi,
    input logic             tgl,
    input scl_phase_e       phase,
    input logic [CNT_W-1:0] cnt,
    input scl_cfg_t         cfg_q,
    input logic             legal_in
);
    // R5
    one_phase_chk: assert property (@(posedge clk) disable iff (rst)
        $countones({lo, hi}) == 1);

    // R6
    tgl_on_change_chk: assert property (@(posedge clk) disable iff (rst)
        tgl |-> (lo != $past(lo)) || (lo && $past(phase) == PH_HIGH));

    // R6
    low_end_tgl_chk: assert property (@(posedge clk) disable iff (rst)
        $fell(lo) |-> (hi && tgl));

    // R8
    cfg_hold_chk: assert property (@(posedge clk) disable iff (rst)
        !$stable(cfg_q) |-> (lo && tgl));

    // R7
    park_chk: assert property (@(posedge clk) disable iff (rst)
        (phase == PH_HIGH && cnt == '0 && !legal_in) |=> (hi && !lo && !tgl));

    // R9
    restart_chk: assert property (@(posedge clk) disable iff (rst)
        (phase == PH_IDLE && legal_in) |=> (lo && tgl));

    // R3
    low_bound_chk: assert property (@(posedge clk) disable iff (rst)
        (phase == PH_LOW) |-> (cnt < low_len(cfg_q)));
endmodule

bind i2c_scl_divgen scl_divgen_chk u_chk (
    .clk      (clk),
    .rst      (rst),
    .lo       (scl_lo_en),
    .hi       (scl_hi_en),
    .tgl      (scl_tgl),
    .phase    (phase_w),
    .cnt      (cnt_w),
    .cfg_q    (cfg_q_w),
    .legal_in (legal_w)
);

// File: tb/i2c_scl_divgen_tb.sv
module i2c_scl_divgen_tb;
    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic [7:0] clk_ctrl = 8'h02;
    logic [4:0] ext_div_hi = 5'h00;
    logic       scl_lo_en, scl_hi_en, scl_tgl;
    int         n_cmp = 0;
    int         n_bad = 0;
    int         cyc = 0;

    always #10 clk = ~clk;

    i2c_scl_divgen u_dut (
        .clk        (clk),
        .rst        (rst),
        .clk_ctrl   (clk_ctrl),
        .ext_div_hi (ext_div_hi),
        .scl_lo_en  (scl_lo_en),
        .scl_hi_en  (scl_hi_en),
        .scl_tgl    (scl_tgl)
    );

    task automatic chk(string req, string what, int act, int exp);
        n_cmp++;
        if (act != exp) begin
            n_bad++;
            $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
        end
    endtask

    task automatic finish_run();
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    endtask

    always @(posedge clk) begin
        cyc++;
        if (cyc > 150000) begin
            n_cmp++;
            n_bad++;
            $display("FAIL watchdog: actual %0d expected below 150000 cycles", cyc);
            finish_run();
        end
    end

    // Set N and mode at a falling edge
    task automatic set_cfg(bit fast, int n);
        clk_ctrl   = {fast, 7'(n)};
        ext_div_hi = 5'(n >> 7);
    endtask

    task automatic sync_low();
        int g = 0;
        while (!(scl_lo_en && scl_tgl) && g < 20000) begin
            @(negedge clk);
            g++;
        end
    endtask

    // Called on the first sample of a low phase; ends on the next low start
    task automatic measure(string req, int exp_lo, int exp_hi);
        int lo_n = 0;
        int hi_n = 0;
        int extra = 0;
        do begin
            lo_n++;
            @(negedge clk);
            if (scl_lo_en && scl_tgl) extra++;
        end while (scl_lo_en && lo_n < 20000);
        chk(req, "low phase length", lo_n, exp_lo);
        chk("R6", "low phase stray strobes", extra, 0);
        chk("R6", "strobe on high entry", int'(scl_tgl), 1);
        do begin
            hi_n++;
            @(negedge clk);
        end while (scl_hi_en && !scl_tgl && hi_n < 20000);
        chk(req, "high phase length", hi_n, exp_hi);
        chk("R5", "low follows high", int'(scl_lo_en), 1);
    endtask

    task automatic t_reset();
        repeat (4) @(negedge clk);
        chk("R1", "hi_en in reset", int'(scl_hi_en), 1);
        chk("R1", "lo_en in reset", int'(scl_lo_en), 0);
        chk("R1", "tgl in reset", int'(scl_tgl), 0);
        rst = 1'b0;
        @(negedge clk);
        chk("R9", "low start after reset", int'(scl_lo_en && scl_tgl), 1);
    endtask

    task automatic t_mode(string req, bit fast, int n, int exp_lo, int exp_hi);
        set_cfg(fast, n);
        @(negedge clk);
        sync_low();
        measure(req, exp_lo, exp_hi);
    endtask

    task automatic t_reprogram();
        set_cfg(1'b0, 10);
        @(negedge clk);
        sync_low();
        set_cfg(1'b1, 3);      // change in first low cycle
        measure("R8", 13, 12); // running period keeps old timing
        measure("R8", 10, 5);  // next period: fast, N=3
    endtask

    task automatic t_illegal_running();
        int lo_n = 0;
        int strobes = 0;
        int lo_seen = 0;
        int hi_miss = 0;
        set_cfg(1'b0, 1);      // illegal, presented in first low cycle of fast N=3
        do begin
            lo_n++;
            @(negedge clk);
        end while (scl_lo_en && lo_n < 20000);
        chk("R8", "low length before park", lo_n, 10);
        for (int i = 0; i < 100; i++) begin
            if (scl_tgl) strobes++;
            if (scl_lo_en) lo_seen++;
            if (!scl_hi_en) hi_miss++;
            @(negedge clk);
        end
        chk("R7", "strobes after N=1 (entry only)", strobes, 1);
        chk("R7", "low cycles while parked", lo_seen, 0);
        chk("R7", "released-high misses", hi_miss, 0);
    endtask

    task automatic t_zero_and_restart();
        int bad = 0;
        set_cfg(1'b1, 0);
        for (int i = 0; i < 40; i++) begin
            @(negedge clk);
            if (scl_lo_en || scl_tgl || !scl_hi_en) bad++;
        end
        chk("R7", "activity with N=0", bad, 0);
        set_cfg(1'b0, 2);
        @(negedge clk);
        chk("R9", "restart one cycle after legal N", int'(scl_lo_en && scl_tgl), 1);
        measure("R3", 5, 4);
    endtask

    initial begin
        t_reset();
        measure("R3", 5, 4);                       // std N=2
        t_mode("R3", 1'b0, 10, 13, 12);             // std N=10
        t_mode("R4", 1'b1, 2, 8, 4);                // fast N=2
        t_mode("R4", 1'b1, 10, 24, 12);             // fast N=10
        t_mode("R2", 1'b0, 300, 303, 302);          // split fields: ctrl=0x2C, ext=2
        t_mode("R2", 1'b1, 4095, 8194, 4097);       // all-ones divider, fast
        t_reprogram();
        t_illegal_running();
        t_zero_and_restart();
        finish_run();
    end
endmodule